// File: doc/BRIEF.md
# Stateful Implication Bit Array

This block is a cycle-level digital model of a small array of non-volatile one-bit cells. The only ways to change a cell are an unconditional clear and a conditional implication write. In the implication write, the destination cell is both an operand and the place the result goes. Any Boolean function can be built from sequences of these two operations, so the array lets a controller run such sequences and check their results.

Commands arrive on a valid/ready port. Each command has a 2-bit opcode, a source index and a destination index. The array accepts at most one command per clock. A read command returns the selected cell on a separate valid/data output.

Two cost figures are kept for the sequence being run:
- A pulse count. It rises by one for every clear or implication.
- An area figure. It is the number of input cells plus the number of distinct work cells that have been written.

A side load port presets cells without touching either cost figure. Analog effects and physical pulse timing are not modelled.

Top module: `impl_cell_array`

## Requirements
- R1: A synchronous active-high reset sets every cell to 0 and the pulse count to 0. It also sets the area figure to the number of input cells, WORK_BASE (8 by default), and holds rd_valid low. After reset is released, cmd_ready is 1.
- R2: An accepted IMPLY (cmd_op = 2'b10) whose source cell cmd_src holds 0 sets the destination cell cmd_dst to 1, whatever the destination held before.
- R3: An accepted IMPLY whose source cell holds 1 leaves the destination unchanged. No IMPLY changes its source cell. In total the destination becomes (NOT src) OR dst.
- R4: An accepted IMPLY whose source index equals its destination index always leaves that cell at 1.
- R5: An accepted FALSE (cmd_op = 2'b01) forces cell cmd_dst to 0 unconditionally.
- R6: An accepted READ (cmd_op = 2'b11) raises rd_valid for exactly the one cycle after acceptance. In that cycle rd_data equals cell cmd_src, including the effect of a write accepted in the cycle just before. rd_valid is 0 in every other cycle.
- R7: pulse_count rises by exactly 1 in the cycle after each accepted FALSE or IMPLY. It does not change for READ, NOP, idle cycles or loads.
- R8: area_count equals WORK_BASE plus the number of distinct cells with index at least WORK_BASE that have been the destination of an accepted FALSE or IMPLY since reset. A repeated write to the same work cell adds nothing, and writes to cells below WORK_BASE add nothing. The figure updates one cycle after acceptance.
- R9: While load_en is 1, cell load_idx takes load_val, cmd_ready is 0, and no command is accepted. A load changes neither cost figure.
- R10: An accepted NOP (cmd_op = 2'b00) changes no cell and neither cost figure, and produces no read result.
- R11: While cmd_valid is 0, no cell or cost figure changes, whatever the other command inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Array can accept a command this cycle |
| cmd_op | input | 2 | 00 NOP, 01 FALSE, 10 IMPLY, 11 READ |
| cmd_src | input | IDX_W | Source cell (IMPLY operand, READ target) |
| cmd_dst | input | IDX_W | Destination cell (FALSE and IMPLY target) |
| load_en | input | 1 | Preset strobe |
| load_idx | input | IDX_W | Cell to preset |
| load_val | input | 1 | Preset value |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | 1 | Read result |
| pulse_count | output | CNT_W | Number of clear and implication operations |
| area_count | output | AREA_W | Input cells plus distinct work cells written |

## Verification
The hardest case to reach from the ports is a read issued in the cycle straight after the write to the same cell. A read that arrives later would hide a stale read path. The bench drives an IMPLY and then a READ on two consecutive cycles with cmd_valid held high, and expects the updated value in the read result.

A second hard case is a load colliding with a valid command. The bench drives both in the same cycle, then reads back the command's destination cell to confirm that the command was ignored.

The area figure is driven through repeated writes to one work cell and through writes below the work base. Only distinct work cells may add to it.

// File: rtl/impl_pkg.sv
package impl_pkg;
  typedef enum logic [1:0] {
    OP_NOP = 2'b00,
    OP_CLR = 2'b01,
    OP_IMP = 2'b10,
    OP_RD  = 2'b11
  } op_e;

  function automatic logic is_pulse(input op_e op);
    return (op == OP_CLR) || (op == OP_IMP);
  endfunction
endpackage

// File: rtl/impl_cell_store.sv
module impl_cell_store
  import impl_pkg::*;
#(
  parameter int NCELLS = 16,
  localparam int IDX_W = $clog2(NCELLS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             accept,
  input  op_e              op,
  input  logic [IDX_W-1:0] src,
  input  logic [IDX_W-1:0] dst,
  input  logic             load_en,
  input  logic [IDX_W-1:0] load_idx,
  input  logic             load_val,
  output logic             rd_valid,
  output logic             rd_data
);
  logic [NCELLS-1:0] cells_q;
  logic [NCELLS-1:0] cells_nx;
  logic              src_bit;
  logic              dst_bit;

  assign src_bit = cells_q[src];
  assign dst_bit = cells_q[dst];

  // Next state of the array: a load has priority; a command writes only the destination.
  always_comb begin
    cells_nx = cells_q;
    if (load_en) begin
      cells_nx[load_idx] = load_val;
    end else if (accept) begin
      unique case (op)
        OP_CLR:  cells_nx[dst] = 1'b0;
        OP_IMP:  cells_nx[dst] = ~src_bit | dst_bit;
        default: cells_nx = cells_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cells_q  <= '0;
      rd_valid <= 1'b0;
      rd_data  <= 1'b0;
    end else begin
      cells_q  <= cells_nx;
      rd_valid <= accept && (op == OP_RD);
      if (accept && (op == OP_RD)) begin
        rd_data <= src_bit;
      end
    end
  end
endmodule

// File: rtl/impl_cost_track.sv
module impl_cost_track
  import impl_pkg::*;
#(
  parameter int NCELLS    = 16,
  parameter int WORK_BASE = 8,
  parameter int CNT_W     = 16,
  localparam int IDX_W  = $clog2(NCELLS),
  localparam int AREA_W = $clog2(NCELLS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  op_e               op,
  input  logic [IDX_W-1:0]  dst,
  output logic [CNT_W-1:0]  pulse_count,
  output logic [AREA_W-1:0] area_count
);
  logic [NCELLS-1:0] work_mask;
  logic [NCELLS-1:0] used_q;
  logic [NCELLS-1:0] used_nx;
  logic [AREA_W-1:0] used_cnt;
  logic              pulse_hit;

  // Constant mask of the cells that count as work cells.
  for (genvar g = 0; g < NCELLS; g++) begin : g_mask
    assign work_mask[g] = (g >= WORK_BASE);
  end

  assign pulse_hit = accept && is_pulse(op);

  always_comb begin
    used_nx = used_q;
    if (pulse_hit) begin
      used_nx[dst] = used_q[dst] | work_mask[dst];
    end
  end

  always_comb begin
    used_cnt = '0;
    for (int i = 0; i < NCELLS; i++) begin
      used_cnt = used_cnt + {{(AREA_W-1){1'b0}}, used_nx[i]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      used_q      <= '0;
      pulse_count <= '0;
      area_count  <= AREA_W'(WORK_BASE);
    end else begin
      used_q     <= used_nx;
      area_count <= AREA_W'(WORK_BASE) + used_cnt;
      if (pulse_hit) begin
        pulse_count <= pulse_count + 1'b1;
      end
    end
  end
endmodule

// File: rtl/impl_cell_array.sv
module impl_cell_array
  import impl_pkg::*;
#(
  parameter int NCELLS    = 16,
  parameter int WORK_BASE = 8,
  parameter int CNT_W     = 16,
  localparam int IDX_W  = $clog2(NCELLS),
  localparam int AREA_W = $clog2(NCELLS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic [IDX_W-1:0]  cmd_src,
  input  logic [IDX_W-1:0]  cmd_dst,
  input  logic              load_en,
  input  logic [IDX_W-1:0]  load_idx,
  input  logic              load_val,
  output logic              rd_valid,
  output logic              rd_data,
  output logic [CNT_W-1:0]  pulse_count,
  output logic [AREA_W-1:0] area_count
);
  logic ready_q;
  logic accept;
  op_e  op;

  always_ff @(posedge clk) begin
    if (rst) ready_q <= 1'b0;
    else     ready_q <= 1'b1;
  end

  assign cmd_ready = ready_q && !load_en;
  assign accept    = cmd_valid && cmd_ready;
  assign op        = op_e'(cmd_op);

  impl_cell_store #(.NCELLS(NCELLS)) store_i (
    .clk      (clk),
    .rst      (rst),
    .accept   (accept),
    .op       (op),
    .src      (cmd_src),
    .dst      (cmd_dst),
    .load_en  (load_en),
    .load_idx (load_idx),
    .load_val (load_val),
    .rd_valid (rd_valid),
    .rd_data  (rd_data)
  );

  impl_cost_track #(
    .NCELLS    (NCELLS),
    .WORK_BASE (WORK_BASE),
    .CNT_W     (CNT_W)
  ) cost_i (
    .clk         (clk),
    .rst         (rst),
    .accept      (accept),
    .op          (op),
    .dst         (cmd_dst),
    .pulse_count (pulse_count),
    .area_count  (area_count)
  );
endmodule

// File: rtl/impl_cell_array_chk.sv
module impl_cell_array_chk #(
  parameter int NCELLS    = 16,
  parameter int CNT_W     = 16,
  localparam int IDX_W  = $clog2(NCELLS),
  localparam int AREA_W = $clog2(NCELLS + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [1:0]        cmd_op,
  input logic [IDX_W-1:0]  cmd_src,
  input logic [IDX_W-1:0]  cmd_dst,
  input logic              load_en,
  input logic [IDX_W-1:0]  load_idx,
  input logic              load_val,
  input logic              rd_valid,
  input logic              rd_data,
  input logic [CNT_W-1:0]  pulse_count,
  input logic [AREA_W-1:0] area_count
);
  logic acc_rd;
  logic acc_pulse;

  assign acc_rd    = cmd_valid && cmd_ready && (cmd_op == 2'b11);
  assign acc_pulse = cmd_valid && cmd_ready && (cmd_op == 2'b01 || cmd_op == 2'b10);

  p_read_latency_r6: assert property (@(posedge clk) disable iff (rst)
    acc_rd |=> rd_valid);

  p_read_only_r6: assert property (@(posedge clk) disable iff (rst)
    !acc_rd |=> !rd_valid);

  p_pulse_step_r7: assert property (@(posedge clk) disable iff (rst)
    acc_pulse |=> pulse_count == $past(pulse_count) + 1'b1);

  p_pulse_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !acc_pulse |=> $stable(pulse_count));

  p_area_grow_r8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (area_count == $past(area_count) || area_count == $past(area_count) + 1'b1));

  p_load_block_r9: assert property (@(posedge clk) disable iff (rst)
    load_en |-> !cmd_ready);
endmodule

bind impl_cell_array impl_cell_array_chk #(
  .NCELLS (NCELLS),
  .CNT_W  (CNT_W)
) chk_i (.*);

// File: tb/impl_cell_array_tb_top.sv
`timescale 1ns/1ps
module impl_cell_array_tb_top;
  localparam int N     = 16;
  localparam int WB    = 8;
  localparam int CW    = 16;
  localparam int IW    = $clog2(N);
  localparam int AW    = $clog2(N + 1);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cmd_valid = 1'b0;
  logic          cmd_ready;
  logic [1:0]    cmd_op = 2'b00;
  logic [IW-1:0] cmd_src = '0;
  logic [IW-1:0] cmd_dst = '0;
  logic          load_en = 1'b0;
  logic [IW-1:0] load_idx = '0;
  logic          load_val = 1'b0;
  logic          rd_valid;
  logic          rd_data;
  logic [CW-1:0] pulse_count;
  logic [AW-1:0] area_count;

  int n_chk  = 0;
  int n_fail = 0;
  logic [N-1:0] mc   = '0;
  logic [N-1:0] used = '0;
  int exp_pulse = 0;

  always #2 clk = ~clk;

  impl_cell_array #(.NCELLS(N), .WORK_BASE(WB), .CNT_W(CW)) dut_i (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_src(cmd_src), .cmd_dst(cmd_dst),
    .load_en(load_en), .load_idx(load_idx), .load_val(load_val),
    .rd_valid(rd_valid), .rd_data(rd_data),
    .pulse_count(pulse_count), .area_count(area_count)
  );

  task automatic chk(input string tag, input int act, input int exp_v);
    n_chk++;
    if (act != exp_v) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp_v);
    end
  endtask

  function automatic int exp_area();
    return WB + $countones(used);
  endfunction

  task automatic model(input logic [1:0] op, input int s, input int d);
    if (op == 2'b01) mc[d] = 1'b0;
    if (op == 2'b10) mc[d] = ~mc[s] | mc[d];
    if (op == 2'b01 || op == 2'b10) begin
      exp_pulse++;
      if (d >= WB) used[d] = 1'b1;
    end
  endtask

  // One command, then checks of read result and both cost figures (R6, R7, R8).
  task automatic cmd(input logic [1:0] op, input int s, input int d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_src = IW'(s); cmd_dst = IW'(d);
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 2'b00;
    model(op, s, d);
    if (op == 2'b11) begin
      chk("R6 rd_valid after READ", int'(rd_valid), 1);
      chk("R6 rd_data", int'(rd_data), int'(mc[s]));
    end else begin
      chk("R6 rd_valid idle", int'(rd_valid), 0);
    end
    chk("R7 pulse_count", int'(pulse_count), exp_pulse);
    chk("R8 area_count", int'(area_count), exp_area());
  endtask

  task automatic load(input int idx, input logic v);
    @(negedge clk);
    load_en = 1'b1; load_idx = IW'(idx); load_val = v;
    @(negedge clk);
    load_en = 1'b0;
    mc[idx] = v;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 cmd_ready", int'(cmd_ready), 1);
    chk("R1 rd_valid", int'(rd_valid), 0);
    chk("R1 pulse_count", int'(pulse_count), 0);
    chk("R1 area_count", int'(area_count), WB);
    for (int i = 0; i < N; i++) cmd(2'b11, i, 0);
  endtask

  // Five-step pattern for each of the four input combinations (R2, R3).
  task automatic t_imply_truth();
    for (int pat = 0; pat < 4; pat++) begin
      load(0, pat[1]);
      load(1, pat[0]);
      cmd(2'b11, 0, 0);
      cmd(2'b11, 1, 0);
      cmd(2'b10, 0, 1);
      cmd(2'b11, 0, 0);
      chk("R3 source unchanged", int'(mc[0]), int'(pat[1]));
      cmd(2'b11, 1, 0);
      chk(pat[1] ? "R3 keep dst" : "R2 set dst", int'(mc[1]), int'(!pat[1] || pat[0]));
    end
  endtask

  task automatic t_self();
    load(2, 1'b0);
    cmd(2'b10, 2, 2);
    cmd(2'b11, 2, 0);
    chk("R4 self imply from 0", int'(mc[2]), 1);
    cmd(2'b10, 2, 2);
    cmd(2'b11, 2, 0);
    chk("R4 self imply from 1", int'(mc[2]), 1);
  endtask

  task automatic t_false();
    load(3, 1'b1);
    cmd(2'b01, 0, 3);
    cmd(2'b11, 3, 0);
    chk("R5 clear from 1", int'(mc[3]), 0);
    cmd(2'b01, 0, 3);
    cmd(2'b11, 3, 0);
  endtask

  // Write and read on consecutive cycles (R6).
  task automatic t_back_to_back();
    load(4, 1'b1);
    load(5, 1'b0);
    cmd(2'b01, 0, 4);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'b10; cmd_src = IW'(5); cmd_dst = IW'(4);
    @(negedge clk);
    model(2'b10, 5, 4);
    chk("R6 no result for IMPLY", int'(rd_valid), 0);
    cmd_op = 2'b11; cmd_src = IW'(4);
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 2'b00;
    chk("R6 back-to-back valid", int'(rd_valid), 1);
    chk("R6 back-to-back data", int'(rd_data), 1);
    @(negedge clk);
    chk("R6 single-cycle valid", int'(rd_valid), 0);
  endtask

  task automatic t_area();
    cmd(2'b01, 0, 9);
    cmd(2'b10, 0, 9);
    cmd(2'b01, 0, 9);
    cmd(2'b01, 0, 6);
    cmd(2'b10, 1, 12);
    chk("R8 area two work cells", int'(area_count), WB + 2);
  endtask

  task automatic t_load_block();
    int p0;
    load(7, 1'b1);
    p0 = exp_pulse;
    @(negedge clk);
    load_en = 1'b1; load_idx = IW'(10); load_val = 1'b1;
    cmd_valid = 1'b1; cmd_op = 2'b01; cmd_dst = IW'(7);
    #1;
    chk("R9 ready low during load", int'(cmd_ready), 0);
    @(negedge clk);
    load_en = 1'b0; cmd_valid = 1'b0; cmd_op = 2'b00;
    mc[10] = 1'b1;
    chk("R9 pulse unchanged", int'(pulse_count), p0);
    cmd(2'b11, 7, 0);
    chk("R9 blocked command ignored", int'(rd_data), 1);
    cmd(2'b11, 10, 0);
    chk("R9 load value", int'(rd_data), 1);
  endtask

  task automatic t_nop_idle();
    load(11, 1'b1);
    cmd(2'b00, 0, 11);
    cmd(2'b11, 11, 0);
    chk("R10 NOP keeps cell", int'(rd_data), 1);
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 2'b01; cmd_dst = IW'(11);
    @(negedge clk);
    cmd_op = 2'b00;
    chk("R11 idle pulse", int'(pulse_count), exp_pulse);
    chk("R11 idle area", int'(area_count), exp_area());
    cmd(2'b11, 11, 0);
    chk("R11 idle keeps cell", int'(rd_data), 1);
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_imply_truth();
    t_self();
    t_false();
    t_back_to_back();
    t_area();
    t_load_block();
    t_nop_idle();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule